// File: doc/BRIEF.md
# Serial Word Deframer with Data Clock Output

This block sits behind a tone demodulator and turns its recovered bit stream into something a simple shift register or microcontroller can take in directly. The line idles high. Each word on it is ten bits long: a low start bit, eight data bits sent least significant first, and a high stop bit, all at a nominal 1200 baud. The block times the bit centres from a single master clock. It passes the raw line level through to a data output, and it emits one clock edge at the centre of each data bit and none for the framing bits. A downstream device that shifts on the rising edge of that clock therefore collects only the eight payload bits.

When the stop bit has been checked and found high, the block drives an active-low word-ready pulse, half a bit long, that can serve as an interrupt or as a parallel-load strobe. Two plain inputs gate all of this. While the carrier-present input is low, the line is ignored and the data output is forced high. While the power-down input is high, all three outputs are parked high.

The bit period is a parameter counted in master clocks. At the intended 3.579545 MHz master clock it is 2983.

Top module: `serial_word_deframer`

## Requirements
- R1: After reset, with carrier present and the line idle high, dataOut is 1, dclkOut is 0 and readyN is 1.
- R2: While carrierOn is 1 and powerDown is 0, dataOut equals rxBit with no register in between.
- R3: A frame that is received intact produces exactly 8 rising edges on dclkOut. No edge is produced for the start bit or the stop bit.
- R4: Rising edge k of dclkOut (k = 0 to 7) falls within 3 master clocks of the centre of data bit k. That centre lies 1.5 + k bit periods after the falling edge of the start bit. At that edge dataOut carries data bit k, the bits being sent least significant first. Each dclkOut high phase lasts half a bit period.
- R5: A frame whose stop bit is high drives readyN low once. The low phase begins within 3 master clocks of the stop-bit centre, 9.5 bit periods after the start edge, and lasts half a bit period (within 1 clock).
- R6: A frame whose stop bit samples low still yields its 8 data clocks but produces no readyN pulse.
- R7: A low pulse on the line that is shorter than half a bit period is rejected as a false start and produces no dclkOut edge.
- R8: While carrierOn is 0, dataOut is 1, dclkOut stays 0 and readyN stays 1. If carrier drops in the middle of a frame, the rest of that frame produces no clock edge and no ready pulse.
- R9: While powerDown is 1, dataOut, dclkOut and readyN are all 1, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master timing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBit | input | 1 | Recovered serial line, idle high |
| carrierOn | input | 1 | High while a carrier is present |
| powerDown | input | 1 | High parks the block with all outputs high |
| dataOut | output | 1 | Gated pass-through of the line |
| dclkOut | output | 1 | Data clock, rising at each data-bit centre |
| readyN | output | 1 | Active-low end-of-word pulse |

## Verification
The bench builds the block with a bit period of 40 master clocks instead of 2983. A full frame then takes about 400 cycles, so several dozen randomly valued words fit in a short run. With a half period of 20, an off-by-one in the centre timing, in the pulse width or in the data-bit count shows up as a clear shift against a 3-clock window. The same timer and counter paths run as at full size, so the clock-edge placement, the stop-bit check, false-start rejection and carrier or power-down interruptions mid-frame can all be reached many times.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } frameState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic dclkFire;   // rising data-clock edge at a data-bit centre
    logic readyFire;  // start of the word-ready pulse
    logic abort;      // carrier lost or powered down: clear pulses
  } frameStrobe_t;

endpackage

// File: rtl/deframer_pulse.sv
module deframer_pulse #(
  parameter int LEN = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  input  logic clear,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      remain <= '0;
    end else if (clear) begin
      active <= 1'b0;
      remain <= '0;
    end else if (fire) begin
      active <= 1'b1;
      remain <= CW'(LEN - 1);
    end else if (active) begin
      if (remain == '0) active <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/deframer_datapath.sv
module deframer_datapath
  import deframer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 2983
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxBit,
  input  logic         carrierOn,
  input  logic         powerDown,
  input  frameStrobe_t strb,
  output logic         rxSync,
  output logic         rxFall,
  output logic         dataOut,
  output logic         dclkOut,
  output logic         readyN
);
  localparam int HALF = CLKS_PER_BIT / 2;

  logic rxQ, rxPrev;
  logic dclkActive, readyActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ    <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxQ    <= rxBit;
      rxPrev <= rxQ;
    end
  end

  assign rxSync = rxQ;
  assign rxFall = rxPrev & ~rxQ;

  deframer_pulse #(.LEN(HALF)) dclkPulse_i (
    .clk(clk), .rstN(rstN), .fire(strb.dclkFire), .clear(strb.abort),
    .active(dclkActive)
  );

  deframer_pulse #(.LEN(HALF)) readyPulse_i (
    .clk(clk), .rstN(rstN), .fire(strb.readyFire), .clear(strb.abort),
    .active(readyActive)
  );

  assign dataOut = (powerDown | ~carrierOn) ? 1'b1 : rxBit;
  assign dclkOut = powerDown | dclkActive;
  assign readyN  = powerDown | ~readyActive;

  AST_DCLK_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strb.dclkFire |=> dclkOut);  // R3
  AST_READY_FOLLOWS_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strb.readyFire |=> (!readyN || powerDown));  // R5
  AST_ABORT_QUIETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (powerDown || (!dclkOut && readyN)));  // R8
  AST_PD_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> (dataOut && dclkOut && readyN));  // R9

endmodule

// File: rtl/deframer_ctrl.sv
module deframer_ctrl
  import deframer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 2983,
  parameter int DATA_BITS    = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         rxSync,
  input  logic         rxFall,
  output frameStrobe_t strb
);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam int TW   = $clog2(CLKS_PER_BIT);
  localparam int BW   = $clog2(DATA_BITS);

  frameState_t   state;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitCnt;
  logic          tick;

  assign tick = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (rxFall) begin
          state <= ST_START;
          timer <= TW'(HALF - 1);
        end
        ST_START: if (!tick) timer <= timer - 1'b1;
          else if (!rxSync) begin
            state  <= ST_DATA;
            timer  <= TW'(CLKS_PER_BIT - 1);
            bitCnt <= '0;
          end else state <= ST_IDLE;
        ST_DATA: if (!tick) timer <= timer - 1'b1;
          else begin
            timer  <= TW'(CLKS_PER_BIT - 1);
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == BW'(DATA_BITS - 1)) state <= ST_STOP;
          end
        ST_STOP: if (!tick) timer <= timer - 1'b1;
          else state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.dclkFire  = enable && (state == ST_DATA) && tick;
    strb.readyFire = enable && (state == ST_STOP) && tick && rxSync;
    strb.abort     = !enable;
  end

  AST_FIRES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dclkFire, strb.readyFire}));  // R5
  AST_IDLE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxFall) |=> (state == ST_IDLE));  // R7
  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_IDLE));  // R8

endmodule

// File: rtl/serial_word_deframer.sv
module serial_word_deframer
  import deframer_pkg::*;
#(
  parameter int CLKS_PER_BIT = 2983
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  input  logic carrierOn,
  input  logic powerDown,
  output logic dataOut,
  output logic dclkOut,
  output logic readyN
);
  frameStrobe_t strb;
  logic rxSync, rxFall, enable;

  assign enable = carrierOn & ~powerDown;

  deframer_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(8)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .rxSync(rxSync),
    .rxFall(rxFall), .strb(strb)
  );

  deframer_datapath #(.CLKS_PER_BIT(CLKS_PER_BIT)) dp_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .carrierOn(carrierOn),
    .powerDown(powerDown), .strb(strb), .rxSync(rxSync), .rxFall(rxFall),
    .dataOut(dataOut), .dclkOut(dclkOut), .readyN(readyN)
  );

endmodule

// File: tb/serial_word_deframer_tb.sv
module serial_word_deframer_tb_top;
  localparam int CPB  = 40;
  localparam int HALF = CPB / 2;
  localparam int TOL  = 3;

  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b1, carrierOn = 1'b1, powerDown = 1'b0;
  logic dataOut, dclkOut, readyN;

  serial_word_deframer #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .carrierOn(carrierOn),
    .powerDown(powerDown), .dataOut(dataOut), .dclkOut(dclkOut), .readyN(readyN)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int frameStart = 0, riseCount = 0, readyCount = 0, readyFallAt = 0;
  logic [7:0] sentByte = 8'h00;
  bit timingOn = 0;
  logic dclkPrev = 1'b0, readyPrev = 1'b1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absDiff(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int expRises(int dropAtBit);
    if (dropAtBit < 0) return 8;
    if (dropAtBit <= 1) return 0;
    return (dropAtBit - 1 > 8) ? 8 : dropAtBit - 1;
  endfunction

  function automatic int expReadies(int dropAtBit, bit stopOk);
    return (dropAtBit < 0 && stopOk) ? 1 : 0;
  endfunction

  // Monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (dclkOut && !dclkPrev) begin
      if (timingOn) begin
        int exp;
        exp = CPB + HALF + riseCount * CPB;
        check(absDiff(cyc - frameStart, exp) <= TOL, "R4 dclk centre timing",
              cyc - frameStart, exp);
        if (riseCount < 8)
          check(dataOut == sentByte[riseCount], "R4 data bit at dclk edge",
                int'(dataOut), int'(sentByte[riseCount]));
      end
      riseCount++;
    end
    if (!readyN && readyPrev) begin
      readyCount++;
      readyFallAt = cyc;
      if (timingOn)
        check(absDiff(cyc - frameStart, 9 * CPB + HALF) <= TOL, "R5 ready start",
              cyc - frameStart, 9 * CPB + HALF);
    end
    if (readyN && !readyPrev && timingOn && !powerDown)
      check(absDiff(cyc - readyFallAt, HALF) <= 1, "R5 ready width",
            cyc - readyFallAt, HALF);
    dclkPrev  = dclkOut;
    readyPrev = readyN;
  end

  task automatic sendFrame(input logic [7:0] b, input bit stopOk, input int dropAtBit);
    @(negedge clk);
    sentByte = b; riseCount = 0; readyCount = 0; timingOn = 1; frameStart = cyc;
    for (int i = 0; i < 10; i++) begin
      if (i == dropAtBit) carrierOn = 1'b0;
      rxBit = (i == 0) ? 1'b0 : (i == 9) ? stopOk : b[i-1];
      #1;
      if (powerDown) begin
        check(dataOut && dclkOut && readyN, "R9 outputs parked high",
              int'({dataOut, dclkOut, readyN}), 7);
      end else if (!carrierOn) begin
        check(dataOut == 1'b1, "R8 data forced high", int'(dataOut), 1);
      end else begin
        check(dataOut == rxBit, "R2 data pass-through", int'(dataOut), int'(rxBit));
      end
      repeat (CPB) @(negedge clk);
      if (!carrierOn && !powerDown)
        check(!dclkOut && readyN, "R8 quiet without carrier",
              int'({dclkOut, readyN}), 1);
    end
    rxBit = 1'b1;
    repeat (HALF + 4 + ($urandom % 8)) @(negedge clk);
    carrierOn = 1'b1;
    timingOn = 0;
  endtask

  task automatic runFrame(input logic [7:0] b, input bit stopOk, input int dropAtBit,
                          input string req);
    sendFrame(b, stopOk, dropAtBit);
    if (!powerDown) begin
      check(riseCount == expRises(dropAtBit), {req, " dclk edge count"},
            riseCount, expRises(dropAtBit));
      check(readyCount == expReadies(dropAtBit, stopOk), {req, " ready count"},
            readyCount, expReadies(dropAtBit, stopOk));
    end else begin
      check(riseCount == 0 && readyCount == 0, "R9 no activity in power-down",
            riseCount + readyCount, 0);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(dataOut == 1 && dclkOut == 0 && readyN == 1, "R1 reset state",
          int'({dataOut, dclkOut, readyN}), 3'b101);

    // Directed corners
    runFrame(8'hA5, 1'b1, -1, "R3");
    runFrame(8'h00, 1'b1, -1, "R3");
    runFrame(8'hFF, 1'b1, -1, "R5");
    runFrame(8'h3C, 1'b0, -1, "R6");
    runFrame(8'h5A, 1'b1, 4, "R8 mid-frame drop");
    runFrame(8'h81, 1'b1, 0, "R8 no carrier");

    // False start shorter than half a bit
    @(negedge clk);
    riseCount = 0; readyCount = 0;
    rxBit = 1'b0;
    repeat (HALF / 2) @(negedge clk);
    rxBit = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    check(riseCount == 0 && readyCount == 0, "R7 false start rejected",
          riseCount + readyCount, 0);

    // Power-down
    @(negedge clk);
    powerDown = 1'b1;
    repeat (2) @(negedge clk);
    rxBit = 1'b0;
    #1;
    check(dataOut && dclkOut && readyN, "R9 parked with line low",
          int'({dataOut, dclkOut, readyN}), 7);
    rxBit = 1'b1;
    repeat (2) @(negedge clk);
    runFrame(8'h96, 1'b1, -1, "R9");
    powerDown = 1'b0;
    repeat (4) @(negedge clk);
    runFrame(8'h69, 1'b1, -1, "R3 after wake");

    // Random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      bit stopOk;
      b = 8'($urandom);
      stopOk = ($urandom % 5) != 0;
      runFrame(b, stopOk, -1, stopOk ? "R5" : "R6");
    end

    finishRun();
  end

endmodule